// File: doc/BRIEF.md
# Octal Digit Sequence Recognizer

This block watches a stream of 3-bit digits, one per clock, and drives `digit_hit` high in any cycle where the digit on the input and the three digits accepted just before it form the sequence 1, 0, 2, 6. The sequence is read from the newest digit to the oldest, so in arrival order the stream carries 6, then 2, then 0, then 1. There is no state machine. Each of the three digit bit lines feeds its own short shift register. Each register holds that bit's last three values and compares them, together with the live bit, against a fixed 4-bit slice of the sequence. The three slice matches are ANDed.

A second, independent recognizer of the same construction watches a single serial bit line. It raises `bit_hit` when the live bit and the five bits before it, newest first, read 1, 0, 0, 1, 0, 1.

Both outputs are combinational from the live input and the stored history. The hit therefore appears in the same cycle as the last symbol of the sequence. Every occurrence is reported, including occurrences that overlap an earlier one.

Top module: `octal_seq_recognizer`

## Requirements
- R1: `digit_hit` is 1 exactly when the live `digit_in` equals 1 and the three previously clocked digits, from most recent to oldest, equal 0, 2 and 6.
- R2: `digit_hit` depends combinationally on the live `digit_in`. It rises in the same cycle that the final digit 1 is presented, before that digit is clocked in.
- R3: Sequences that follow each other with no gap (6,2,0,1,6,2,0,1) produce a hit for each occurrence.
- R4: An asynchronous active-low reset clears both histories to zero. Neither output can assert until enough symbols have been clocked in after reset: 3 digits for `digit_hit` and 5 bits for `bit_hit`.
- R5: A difference in any single bit plane at any of the four digit ages suppresses `digit_hit` (for example 7 in place of 6, or 3 in place of 2).
- R6: `bit_hit` is 1 exactly when the live `bit_in` and the five previously clocked bits, from newest to oldest, read 1,0,0,1,0,1.
- R7: Overlapping bit occurrences are all reported. In the bit stream 1,0,1,0,0,1,0,1,0,0,1, `bit_hit` rises at the sixth bit and again at the eleventh.
- R8: The digit and bit recognizers are independent. Activity on `bit_in` never changes `digit_hit`, and activity on `digit_in` never changes `bit_hit`.
- R9: A reset applied part-way through a sequence discards the partial history, so completing that sequence after reset gives no hit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| digit_in | input | 3 | Live octal digit |
| digit_hit | output | 1 | High when the digit sequence 1,0,2,6 (newest first) is present |
| bit_in | input | 1 | Live serial bit |
| bit_hit | output | 1 | High when the bit sequence 1,0,0,1,0,1 (newest first) is present |

## Verification
The hardest case to reach is a near miss in which only one bit plane disagrees. Random digits almost never match three planes and fail a single one. The stimulus therefore runs the exact sequence with one digit altered by a single bit at each of the four ages in turn. It also covers back-to-back sequences, the self-overlapping bit stream, and a reset placed one symbol before completion. A long random run follows, with the full sequence inserted from time to time.

// File: rtl/seqrec_pkg.sv
package seqrec_pkg;
    localparam int DIGIT_W   = 3;
    localparam int DIGIT_LEN = 4;
    localparam int BIT_LEN   = 6;
    // Digit at age k sits in bits [k*DIGIT_W +: DIGIT_W]; age 0 is the live digit.
    localparam logic [DIGIT_LEN*DIGIT_W-1:0] DIGIT_SEQ = {3'd6, 3'd2, 3'd0, 3'd1};
    // Bit k is the value expected at age k (newest first 1,0,0,1,0,1).
    localparam logic [BIT_LEN-1:0] BIT_SEQ = 6'b101001;
endpackage

// File: rtl/shift_history.sv
module shift_history #(
    parameter int DEPTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_in,
    output logic [DEPTH-1:0] hist
);
    // hist[0] holds the value from one cycle ago, hist[DEPTH-1] the oldest.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            hist <= '0;
        else
            hist <= {hist[DEPTH-2:0], shift_in};
    end
endmodule

// File: rtl/pattern_compare.sv
module pattern_compare #(
    parameter int             LEN     = 4,
    parameter logic [LEN-1:0] PATTERN = '0
) (
    input  logic           cur,
    input  logic [LEN-2:0] hist,
    output logic           match
);
    logic [LEN-1:0] window;

    always_comb begin
        window = {hist, cur};
        match  = (window == PATTERN);
    end
endmodule

// File: rtl/plane_matcher.sv
module plane_matcher #(
    parameter int             LEN     = 4,
    parameter logic [LEN-1:0] PATTERN = '0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cur,
    output logic match
);
    localparam int HIST = LEN - 1;

    logic [HIST-1:0] hist;

    shift_history #(.DEPTH(HIST)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_in (cur),
        .hist     (hist)
    );

    pattern_compare #(.LEN(LEN), .PATTERN(PATTERN)) u_cmp (
        .cur   (cur),
        .hist  (hist),
        .match (match)
    );
endmodule

// File: rtl/octal_seq_recognizer.sv
module octal_seq_recognizer
    import seqrec_pkg::*;
#(
    parameter int                              D_W   = DIGIT_W,
    parameter int                              D_LEN = DIGIT_LEN,
    parameter logic [DIGIT_LEN*DIGIT_W-1:0]    D_SEQ = DIGIT_SEQ,
    parameter int                              B_LEN = BIT_LEN,
    parameter logic [BIT_LEN-1:0]              B_SEQ = BIT_SEQ
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [D_W-1:0] digit_in,
    output logic           digit_hit,
    input  logic           bit_in,
    output logic           bit_hit
);
    // Slice one bit plane out of the digit sequence, age 0 in bit 0.
    function automatic logic [D_LEN-1:0] plane_pat(input int plane);
        logic [D_LEN-1:0] r;
        for (int k = 0; k < D_LEN; k++)
            r[k] = D_SEQ[k*D_W + plane];
        return r;
    endfunction

    logic [D_W-1:0] plane_match;

    generate
        for (genvar p = 0; p < D_W; p++) begin : g_plane
            plane_matcher #(
                .LEN     (D_LEN),
                .PATTERN (plane_pat(p))
            ) u_plane (
                .clk   (clk),
                .rst_n (rst_n),
                .cur   (digit_in[p]),
                .match (plane_match[p])
            );
        end
    endgenerate

    logic serial_match;

    plane_matcher #(
        .LEN     (B_LEN),
        .PATTERN (B_SEQ)
    ) u_serial (
        .clk   (clk),
        .rst_n (rst_n),
        .cur   (bit_in),
        .match (serial_match)
    );

    always_comb begin
        digit_hit = &plane_match;
        bit_hit   = serial_match;
    end
endmodule

// File: rtl/octal_seq_checker.sv
module octal_seq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] digit_in,
    input logic       digit_hit,
    input logic       bit_in,
    input logic       bit_hit
);
    logic [2:0] since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            since_rst <= '0;
        else if (since_rst != 3'd7)
            since_rst <= since_rst + 3'd1;
    end

    assert_hit_needs_seq_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd3 && digit_hit) |->
        (digit_in == 3'd1 && $past(digit_in, 1) == 3'd0 &&
         $past(digit_in, 2) == 3'd2 && $past(digit_in, 3) == 3'd6));

    assert_seq_gives_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd3 && digit_in == 3'd1 && $past(digit_in, 1) == 3'd0 &&
         $past(digit_in, 2) == 3'd2 && $past(digit_in, 3) == 3'd6) |-> digit_hit);

    assert_digit_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst < 3'd3) |-> !digit_hit);

    assert_bit_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst < 3'd5) |-> !bit_hit);

    assert_bit_needs_seq_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd5 && bit_hit) |->
        (bit_in && !$past(bit_in, 1) && !$past(bit_in, 2) &&
         $past(bit_in, 3) && !$past(bit_in, 4) && $past(bit_in, 5)));

    assert_bit_seq_gives_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd5 && bit_in && !$past(bit_in, 1) && !$past(bit_in, 2) &&
         $past(bit_in, 3) && !$past(bit_in, 4) && $past(bit_in, 5)) |-> bit_hit);
endmodule

bind octal_seq_recognizer octal_seq_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .digit_in  (digit_in),
    .digit_hit (digit_hit),
    .bit_in    (bit_in),
    .bit_hit   (bit_hit)
);

// File: tb/sim_octal_seq_recognizer.sv
module sim_octal_seq_recognizer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] digit_in = 3'd0;
    logic       bit_in = 1'b0;
    logic       digit_hit;
    logic       bit_hit;

    int n_cmp = 0;
    int n_bad = 0;
    int dq[$];
    int bq[$];

    always #5 clk = ~clk;

    octal_seq_recognizer u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .digit_in  (digit_in),
        .digit_hit (digit_hit),
        .bit_in    (bit_in),
        .bit_hit   (bit_hit)
    );

    task automatic model_clear();
        dq = {0, 0, 0};
        bq = {0, 0, 0, 0, 0};
    endtask

    task automatic compare(input string tag);
        logic exp_d, exp_b;
        exp_d = (int'(digit_in) == 1) && dq[0] == 0 && dq[1] == 2 && dq[2] == 6;
        exp_b = bit_in && bq[0] == 0 && bq[1] == 0 && bq[2] == 1 && bq[3] == 0 && bq[4] == 1;
        n_cmp++;
        if (digit_hit !== exp_d) begin
            n_bad++;
            $display("FAIL %s digit_hit actual=%b expected=%b", tag, digit_hit, exp_d);
        end
        n_cmp++;
        if (bit_hit !== exp_b) begin
            n_bad++;
            $display("FAIL %s bit_hit actual=%b expected=%b", tag, bit_hit, exp_b);
        end
    endtask

    task automatic step(input logic [2:0] d, input logic b, input string tag);
        @(negedge clk);
        digit_in = d;
        bit_in   = b;
        #1;
        compare(tag);
        @(posedge clk);
        if (rst_n) begin
            dq.push_front(int'(d)); void'(dq.pop_back());
            bq.push_front(int'(b)); void'(bq.pop_back());
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        model_clear();
        digit_in = 3'd1;
        bit_in   = 1'b1;
        #1;
        compare("R4");
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic digit_seq(input int a, input int b, input int c, input int d, input string tag);
        step(a[2:0], 1'b0, tag);
        step(b[2:0], 1'b0, tag);
        step(c[2:0], 1'b0, tag);
        step(d[2:0], 1'b0, tag);
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        model_clear();
        do_reset();
        // R4: live 1 with cleared history must not hit
        step(3'd1, 1'b1, "R4");
        step(3'd1, 1'b1, "R4");

        // R1 / R2: plain occurrence, hit on the live final digit
        digit_seq(6, 2, 0, 1, "R1");
        step(3'd0, 1'b0, "R2");

        // R3: back-to-back occurrences
        digit_seq(6, 2, 0, 1, "R3");
        digit_seq(6, 2, 0, 1, "R3");
        digit_seq(6, 2, 0, 1, "R3");

        // R5: single-bit-plane near misses at each age
        digit_seq(7, 2, 0, 1, "R5");
        digit_seq(6, 3, 0, 1, "R5");
        digit_seq(6, 2, 4, 1, "R5");
        digit_seq(6, 2, 0, 5, "R5");
        digit_seq(4, 2, 0, 1, "R5");
        digit_seq(6, 2, 0, 3, "R5");

        // R6 / R7: bit sequence and its overlapping repeat
        step(3'd0, 1'b1, "R6"); step(3'd0, 1'b0, "R6"); step(3'd0, 1'b1, "R6");
        step(3'd0, 1'b0, "R6"); step(3'd0, 1'b0, "R6"); step(3'd0, 1'b1, "R6");
        step(3'd0, 1'b0, "R7"); step(3'd0, 1'b1, "R7"); step(3'd0, 1'b0, "R7");
        step(3'd0, 1'b0, "R7"); step(3'd0, 1'b1, "R7");

        // R8: each recognizer fires while the other line carries noise
        step(3'd6, 1'b1, "R8"); step(3'd2, 1'b0, "R8"); step(3'd0, 1'b1, "R8");
        step(3'd1, 1'b0, "R8"); step(3'd7, 1'b0, "R8"); step(3'd3, 1'b1, "R8");
        step(3'd5, 1'b1, "R8"); step(3'd2, 1'b1, "R8");

        // R9: reset one symbol before completion
        step(3'd6, 1'b1, "R9"); step(3'd2, 1'b0, "R9"); step(3'd0, 1'b1, "R9");
        step(3'd0, 1'b0, "R9"); step(3'd0, 1'b0, "R9");
        do_reset();
        step(3'd1, 1'b1, "R9");
        step(3'd0, 1'b0, "R9");

        // R1: random stream with occasional inserted sequences
        for (int i = 0; i < 600; i++) begin
            if ($urandom_range(0, 19) == 0)
                digit_seq(6, 2, 0, 1, "R1");
            else
                step(3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)), "R1");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule